// File: doc/BRIEF.md
# Two-Wire Byte Shift Unit

This block moves one byte at a time over an open-drain, two-wire (I2C-style) bus on behalf of a CPU. Software does the protocol work: it writes a byte into a left-shifting data register, sets the pin directions and latches, and either lets a remote master clock the bus or makes clock edges itself by writing a toggle bit. Hardware shifts the sampled data line into bit 0 on every rising clock, counts both clock edges in a small counter, and raises flags for start conditions, stop conditions and counter wrap. It can also stretch the clock by holding SCL low until software acknowledges a flag.

Both bus lines are modelled as open-drain. Each output port is a pull-low enable, and each input is the level seen on the wired-AND line. The inputs pass through a synchroniser before any edge or condition is detected. Register access uses a write strobe with an address, and a combinational read port with its own address.

Top module: `twb_shift_unit`

## Requirements
- R1: After reset the control register (address 0), status register (address 1) and data register (address 2) all read 0, and neither pull-low output is asserted.
- R2: While control bit 6 (enable) is 0, neither line is pulled low, rising clock edges do not shift the data register, the counter does not advance, and no start, stop or overflow flag is set. Data and status writes still take effect.
- R3: `sda_pull_o` is 1 exactly when enable is 1, control bit 4 (SDA output) is 1, and the AND of control bit 2 (SDA latch) with data bit 7 is 0.
- R4: While enabled, each rising SCL level seen by the unit shifts the data register left by one place and loads the synchronised SDA level into bit 0. The register update lands on the third rising clock after the pin changes.
- R5: While enabled, the counter (status bits 3:0) advances by one on every rising and every falling SCL edge. A step from 15 to 0 sets the overflow flag (status bit 6).
- R6: While enabled, SDA falling while SCL is high sets the start flag (status bit 7). While the start flag is set and control bit 3 (SCL output) is 1, SCL is pulled low.
- R7: With control bit 5 (overflow hold) set, a set overflow flag also pulls SCL low, provided the SCL output bit is set. With bit 5 clear, overflow does not hold SCL.
- R8: While enabled, SDA rising while SCL is high sets the stop flag (status bit 5).
- R9: A status write clears each of bits 7, 6 and 5 that is written as 1 and leaves any bit written as 0 unchanged. The same write loads bits 3:0 into the counter.
- R10: Status bit 4 (collision) reads live as enable AND data bit 7 AND (synchronised SDA low) AND (synchronised SCL high). Writes do not affect it.
- R11: A control write with bit 0 set inverts the SCL latch (control bit 1) and ignores the written bit 1. Control bit 0 always reads back 0. A cleared SCL latch pulls SCL low when the SCL output bit is set.
- R12: When a register write and a bus event land in the same cycle, the following rules apply. A counter load beats the edge increment. An overflow set beats a write-1 clear. A data write beats the shift.
- R13: Reading address 3 returns the synchronised SDA level in bit 0 and the synchronised SCL level in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status, 2 data |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 status, 2 data, 3 pins |
| rd_data | output | DATA_W | Combinational read data |
| sda_i | input | 1 | Level observed on the SDA line |
| scl_i | input | 1 | Level observed on the SCL line |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |

## Verification
The risky overlap is a software status or data write that lands on the same clock as an SCL edge reaching the counter and shifter. In particular, a counter load and an overflow-flag clear can coincide with the 15-to-0 wrap. The bench provokes this by moving the bus line and raising the write strobe two falling clock edges later, so both reach the registers on one edge. It then expects the loaded count to win, the overflow flag to stay set, and a coincident data write to override the shift. A second overlap occurs when the clock-hold output drives the bus: the held line itself produces a counted edge. The expected counts are adjusted for that.

// File: rtl/twb_pkg.sv
package twb_pkg;

   // register addresses (shared by write and read ports)
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_PINS = 2'd3
   } twb_reg_e;

   // control register bit positions
   localparam int CTL_TOGGLE   = 0;
   localparam int CTL_SCL_LAT  = 1;
   localparam int CTL_SDA_LAT  = 2;
   localparam int CTL_SCL_DIR  = 3;
   localparam int CTL_SDA_DIR  = 4;
   localparam int CTL_OVF_HOLD = 5;
   localparam int CTL_ENABLE   = 6;
   localparam int CTL_MIN_W    = CTL_ENABLE + 1;

   // number of write-1-to-clear event flags
   localparam int NUM_FLAGS = 3;
   localparam int FLG_STOP  = 0;
   localparam int FLG_OVF   = 1;
   localparam int FLG_START = 2;

   typedef struct packed {
      logic enable;
      logic ovf_hold;
      logic sda_dir;
      logic scl_dir;
      logic sda_lat;
      logic scl_lat;
   } twb_ctrl_t;

endpackage

// File: rtl/twb_pin_sync.sv
module twb_pin_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("twb_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE_LVL}};
         prev_q  <= IDLE_LVL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/twb_shift_core.sv
module twb_shift_core #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_lvl_i,
   input  logic              data_wr_i,
   input  logic              cnt_wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] data_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              wrap_o
);

   localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              edge_any;

   assign edge_any = en_i & (scl_rise_i | scl_fall_i);

   // software load has priority over the bus shift
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (data_wr_i) begin
         data_q <= wr_data_i;
      end else if (en_i && scl_rise_i) begin
         data_q <= {data_q[DATA_W-2:0], sda_lvl_i};
      end
   end

   // software load has priority over the edge increment
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_wr_i) begin
         cnt_q <= wr_data_i[CNT_W-1:0];
      end else if (edge_any) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   // wrap is reported even when a load wins the counter
   assign wrap_o = edge_any & (cnt_q == CNT_LAST);
   assign data_o = data_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/twb_flag_bank.sv
module twb_flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q;
      // a hardware set beats a write-1 clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (set_i[i]) begin
            flag_q <= 1'b1;
         end else if (clr_i[i]) begin
            flag_q <= 1'b0;
         end
      end
      assign flag_o[i] = flag_q;
   end

endmodule

// File: rtl/twb_shift_unit.sv
module twb_shift_unit
   import twb_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sda_i,
   input  logic              scl_i,
   output logic              sda_pull_o,
   output logic              scl_pull_o
);

   localparam int ST_COLL  = CNT_W;
   localparam int ST_STOP  = CNT_W + 1;
   localparam int ST_OVF   = CNT_W + 2;
   localparam int ST_START = CNT_W + 3;
   localparam int ST_W     = CNT_W + 4;

   if (DATA_W < CTL_MIN_W) begin : g_bad_data_w
      $error("twb_shift_unit: DATA_W too narrow for the control register");
   end
   if (ST_W > DATA_W) begin : g_bad_cnt_w
      $error("twb_shift_unit: CNT_W plus four flags exceeds DATA_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt_min
      $error("twb_shift_unit: CNT_W must be positive");
   end

   // ---------------- register write decode ----------------
   logic ctrl_wr, stat_wr, data_wr;
   assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
   assign stat_wr = wr_en && (wr_addr == REG_STAT);
   assign data_wr = wr_en && (wr_addr == REG_DATA);

   twb_ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q.enable   <= wr_data[CTL_ENABLE];
         ctrl_q.ovf_hold <= wr_data[CTL_OVF_HOLD];
         ctrl_q.sda_dir  <= wr_data[CTL_SDA_DIR];
         ctrl_q.scl_dir  <= wr_data[CTL_SCL_DIR];
         ctrl_q.sda_lat  <= wr_data[CTL_SDA_LAT];
         ctrl_q.scl_lat  <= wr_data[CTL_TOGGLE] ? ~ctrl_q.scl_lat
                                                : wr_data[CTL_SCL_LAT];
      end
   end

   logic en;
   assign en = ctrl_q.enable;

   // ---------------- pin synchronisers ----------------
   logic sda_lvl, sda_rise, sda_fall;
   logic scl_lvl, scl_rise, scl_fall;

   twb_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sda_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (sda_i),
      .level_o (sda_lvl),
      .rise_o  (sda_rise),
      .fall_o  (sda_fall)
   );

   twb_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_scl_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (scl_i),
      .level_o (scl_lvl),
      .rise_o  (scl_rise),
      .fall_o  (scl_fall)
   );

   // ---------------- shifter and edge counter ----------------
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              cnt_wrap;

   twb_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .sda_lvl_i  (sda_lvl),
      .data_wr_i  (data_wr),
      .cnt_wr_i   (stat_wr),
      .wr_data_i  (wr_data),
      .data_o     (data_q),
      .cnt_o      (cnt_q),
      .wrap_o     (cnt_wrap)
   );

   // ---------------- bus conditions and flags ----------------
   logic                 start_seen, stop_seen;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;

   assign start_seen = en & sda_fall & scl_lvl;
   assign stop_seen  = en & sda_rise & scl_lvl;

   always_comb begin
      flag_set            = '0;
      flag_set[FLG_START] = start_seen;
      flag_set[FLG_OVF]   = cnt_wrap;
      flag_set[FLG_STOP]  = stop_seen;
      flag_clr            = '0;
      flag_clr[FLG_START] = stat_wr & wr_data[ST_START];
      flag_clr[FLG_OVF]   = stat_wr & wr_data[ST_OVF];
      flag_clr[FLG_STOP]  = stat_wr & wr_data[ST_STOP];
   end

   twb_flag_bank #(.N(NUM_FLAGS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set),
      .clr_i  (flag_clr),
      .flag_o (flags)
   );

   logic start_flag, ovf_flag, stop_flag;
   assign start_flag = flags[FLG_START];
   assign ovf_flag   = flags[FLG_OVF];
   assign stop_flag  = flags[FLG_STOP];

   logic start_clr;
   assign start_clr = flag_clr[FLG_START];

   // ---------------- open-drain outputs ----------------
   logic scl_hold;
   logic collision;

   assign scl_hold   = start_flag | (ctrl_q.ovf_hold & ovf_flag);
   assign sda_pull_o = en & ctrl_q.sda_dir & ~(ctrl_q.sda_lat & data_q[DATA_W-1]);
   assign scl_pull_o = en & ctrl_q.scl_dir & (~ctrl_q.scl_lat | scl_hold);
   assign collision  = en & data_q[DATA_W-1] & ~sda_lvl & scl_lvl;

   // ---------------- read port ----------------
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         REG_CTRL: begin
            rd_data[CTL_ENABLE]   = ctrl_q.enable;
            rd_data[CTL_OVF_HOLD] = ctrl_q.ovf_hold;
            rd_data[CTL_SDA_DIR]  = ctrl_q.sda_dir;
            rd_data[CTL_SCL_DIR]  = ctrl_q.scl_dir;
            rd_data[CTL_SDA_LAT]  = ctrl_q.sda_lat;
            rd_data[CTL_SCL_LAT]  = ctrl_q.scl_lat;
         end
         REG_STAT: begin
            rd_data[CNT_W-1:0] = cnt_q;
            rd_data[ST_COLL]   = collision;
            rd_data[ST_STOP]   = stop_flag;
            rd_data[ST_OVF]    = ovf_flag;
            rd_data[ST_START]  = start_flag;
         end
         REG_DATA: rd_data = data_q;
         REG_PINS: begin
            rd_data[0] = sda_lvl;
            rd_data[1] = scl_lvl;
         end
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/twb_shift_unit_chk.sv
module twb_shift_unit_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              ovf_hold,
   input logic              scl_dir,
   input logic              sda_pull,
   input logic              scl_pull,
   input logic              scl_rise,
   input logic              scl_fall,
   input logic [DATA_W-1:0] data_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              ovf_flag,
   input logic              start_flag,
   input logic              data_wr,
   input logic              stat_wr,
   input logic              start_clr
);

   localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!sda_pull && !scl_pull)); // R2

   AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en) && !$past(data_wr)) |-> $stable(data_q)); // R2

   AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && $past(scl_rise) && !$past(data_wr))
         |-> (data_q[DATA_W-1:1] == $past(data_q[DATA_W-2:0]))); // R4

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && ($past(scl_rise) || $past(scl_fall)) && !$past(stat_wr))
         |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R5

   AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && ($past(scl_rise) || $past(scl_fall)) && ($past(cnt_q) == CNT_LAST))
         |-> ovf_flag); // R12

   AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start_flag) && en && scl_dir) |-> scl_pull); // R6

   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ovf_flag) && en && ovf_hold && scl_dir) |-> scl_pull); // R7

   AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start_flag) && !$past(start_clr)) |-> start_flag); // R9

endmodule

bind twb_shift_unit twb_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .ovf_hold   (ctrl_q.ovf_hold),
   .scl_dir    (ctrl_q.scl_dir),
   .sda_pull   (sda_pull_o),
   .scl_pull   (scl_pull_o),
   .scl_rise   (scl_rise),
   .scl_fall   (scl_fall),
   .data_q     (data_q),
   .cnt_q      (cnt_q),
   .ovf_flag   (ovf_flag),
   .start_flag (start_flag),
   .data_wr    (data_wr),
   .stat_wr    (stat_wr),
   .start_clr  (start_clr)
);

// File: tb/sim_twb_shift_unit.sv
module sim_twb_shift_unit;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;
   localparam logic [1:0] A_PINS = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       sda_pull, scl_pull;
   logic       tb_sda_low = 1'b0;
   logic       tb_scl_low = 1'b0;
   logic       sda_line, scl_line;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   // wired-AND bus
   assign sda_line = ~(sda_pull | tb_sda_low);
   assign scl_line = ~(scl_pull | tb_scl_low);

   twb_shift_unit u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .sda_i      (sda_line),
      .scl_i      (scl_line),
      .sda_pull_o (sda_pull),
      .scl_pull_o (scl_pull)
   );

   // expected status byte: start 7, ovf 6, stop 5, coll 4, count 3:0
   function automatic logic [7:0] exp_stat(input bit st, input bit ov, input bit sp,
                                           input bit co, input int cnt);
      return {st, ov, sp, co, 4'(cnt)};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic scl_to(input bit v);
      @(negedge clk);
      tb_scl_low = ~v;
      idle(4);
   endtask

   task automatic sda_to(input bit v);
      @(negedge clk);
      tb_sda_low = ~v;
      idle(4);
   endtask

   // SCL moves, and a register write reaches the same clock edge as the edge detector
   task automatic edge_with_write(input bit v, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      tb_scl_low = ~v;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      idle(4);
   endtask

   task automatic bus_home();
      tb_sda_low = 1'b0;
      tb_scl_low = 1'b0;
      reg_wr(A_CTRL, 8'h00);
      idle(4);
      reg_wr(A_STAT, 8'hE0);
   endtask

   initial begin
      logic [7:0] v;
      void'($urandom(32'd5150));
      idle(3);
      rst_n = 1'b1;
      idle(4);

      // ---- R1: reset state ----
      reg_rd(A_CTRL, v); chk("R1", "ctrl after reset", v, 8'h00);
      reg_rd(A_STAT, v); chk("R1", "status after reset", v, 8'h00);
      reg_rd(A_DATA, v); chk("R1", "data after reset", v, 8'h00);
      chk("R1", "pull outputs after reset", {sda_pull, scl_pull}, 2'b00);
      // ---- R13: idle pins ----
      reg_rd(A_PINS, v); chk("R13", "pins idle", v, 8'h03);

      // ---- R2: disabled unit ignores the bus ----
      reg_wr(A_CTRL, 8'h1C);            // SDA/SCL outputs and SDA latch, no enable
      reg_wr(A_DATA, 8'h3C);
      chk("R2", "no pulls when disabled", {sda_pull, scl_pull}, 2'b00);
      sda_to(0);                        // would be a start
      scl_to(0); scl_to(1); scl_to(0); scl_to(1);
      sda_to(1);                        // would be a stop
      reg_rd(A_DATA, v); chk("R2", "data frozen when disabled", v, 8'h3C);
      reg_rd(A_STAT, v); chk("R2", "status quiet when disabled", v, 8'h00);

      // ---- R3: SDA drive = dir AND NOT(latch AND msb) ----
      reg_wr(A_CTRL, 8'h54);
      reg_wr(A_DATA, 8'h80);
      chk("R3", "msb 1 latch 1 releases", sda_pull, 1'b0);
      reg_wr(A_DATA, 8'h00);
      chk("R3", "msb 0 pulls low", sda_pull, 1'b1);
      reg_wr(A_CTRL, 8'h50);
      reg_wr(A_DATA, 8'h80);
      chk("R3", "latch 0 masks msb", sda_pull, 1'b1);
      reg_wr(A_CTRL, 8'h44);
      chk("R3", "input direction releases", sda_pull, 1'b0);
      bus_home();

      // ---- R6 / R13 / R9: start detection and hold ----
      reg_wr(A_CTRL, 8'h4A);            // enable, SCL out, SCL latch 1
      chk("R6", "scl released before start", scl_pull, 1'b0);
      sda_to(0);
      reg_rd(A_STAT, v); chk("R6", "start flag", v[7], 1'b1);
      chk("R6", "scl held after start", scl_pull, 1'b1);
      reg_rd(A_PINS, v); chk("R13", "pins during hold", v, 8'h00);
      reg_wr(A_STAT, 8'h00);            // writing 0 leaves the flag
      reg_rd(A_STAT, v); chk("R9", "write 0 keeps start", v[7], 1'b1);
      reg_wr(A_STAT, 8'h80);
      idle(4);
      reg_rd(A_STAT, v); chk("R9", "write 1 clears start", v[7], 1'b0);
      chk("R6", "scl released after clear", scl_pull, 1'b0);
      // ---- R8: stop ----
      sda_to(1);
      reg_rd(A_STAT, v); chk("R8", "stop flag", v[5], 1'b1);
      reg_wr(A_STAT, 8'h20);
      reg_rd(A_STAT, v); chk("R9", "stop cleared", v[5], 1'b0);
      bus_home();

      // ---- R7: overflow hold ----
      reg_wr(A_CTRL, 8'h6A);
      reg_wr(A_STAT, 8'hEF);            // count 15
      scl_to(0);                        // wrap on falling edge
      reg_rd(A_STAT, v); chk("R7", "ovf set, count 0", v, exp_stat(0, 1, 0, 0, 0));
      chk("R7", "scl held on ovf", scl_pull, 1'b1);
      scl_to(1);                        // bench releases, line stays low
      reg_wr(A_STAT, 8'h40);
      idle(4);
      chk("R7", "scl released after ovf clear", scl_pull, 1'b0);
      reg_rd(A_STAT, v); chk("R5", "release edge counted", v[3:0], 4'd1);
      reg_wr(A_CTRL, 8'h4A);            // hold on overflow off
      reg_wr(A_STAT, 8'hEF);
      scl_to(0);
      reg_rd(A_STAT, v); chk("R7", "ovf without hold", v[6], 1'b1);
      chk("R7", "no hold when bit 5 clear", scl_pull, 1'b0);
      bus_home();

      // ---- R11: software toggle ----
      reg_wr(A_CTRL, 8'h4A);
      reg_wr(A_DATA, 8'h00);
      reg_wr(A_STAT, 8'hE0);
      reg_wr(A_CTRL, 8'h4B);            // invert latch 1 -> 0
      idle(4);
      chk("R11", "toggle pulls scl", scl_pull, 1'b1);
      reg_rd(A_CTRL, v); chk("R11", "ctrl readback", v, 8'h48);
      reg_wr(A_CTRL, 8'h49);            // invert latch 0 -> 1, bit 1 ignored
      idle(4);
      chk("R11", "toggle releases scl", scl_pull, 1'b0);
      reg_rd(A_STAT, v); chk("R11", "two toggled edges counted", v, exp_stat(0, 0, 0, 0, 2));
      reg_rd(A_DATA, v); chk("R4", "toggled rise shifts sda", v, 8'h01);
      bus_home();

      // ---- R10: collision ----
      reg_wr(A_CTRL, 8'h40);
      scl_to(0); sda_to(0); scl_to(1);
      reg_wr(A_DATA, 8'hFF);
      reg_rd(A_STAT, v); chk("R10", "collision msb1 sda0 scl1", v[4], 1'b1);
      reg_wr(A_STAT, 8'h10);
      reg_rd(A_STAT, v); chk("R10", "collision unaffected by write", v[4], 1'b1);
      reg_wr(A_DATA, 8'h7F);
      reg_rd(A_STAT, v); chk("R10", "no collision msb0", v[4], 1'b0);
      scl_to(0);
      reg_wr(A_DATA, 8'hFF);
      reg_rd(A_STAT, v); chk("R10", "no collision scl low", v[4], 1'b0);
      sda_to(1);
      bus_home();

      // ---- R12: coincident write and bus edge ----
      reg_wr(A_CTRL, 8'h40);
      reg_wr(A_DATA, 8'h00);
      reg_wr(A_STAT, 8'hEF);            // count 15
      edge_with_write(0, A_STAT, 8'h45);// wrap + clear ovf + load 5
      reg_rd(A_STAT, v); chk("R12", "load wins, set wins", v, exp_stat(0, 1, 0, 0, 5));
      edge_with_write(1, A_DATA, 8'h5A);
      reg_rd(A_DATA, v); chk("R12", "data write beats shift", v, 8'h5A);
      reg_rd(A_STAT, v); chk("R12", "edge still counted", v[3:0], 4'd6);
      bus_home();

      // ---- R4 / R5: random bytes shifted in by bus clock ----
      reg_wr(A_CTRL, 8'h40);
      for (int b = 0; b < 8; b++) begin
         logic [7:0] byte_v;
         byte_v = 8'($urandom);
         scl_to(0);
         reg_wr(A_STAT, 8'hE0);
         for (int i = 7; i >= 0; i--) begin
            sda_to(byte_v[i]);
            scl_to(1);
            scl_to(0);
         end
         sda_to(1);
         reg_rd(A_DATA, v); chk("R4", "shifted byte", v, byte_v);
         reg_rd(A_STAT, v); chk("R5", "16 edges wrap", v, exp_stat(0, 1, 0, 0, 0));
         scl_to(1);
      end

      // ---- R5 / R9: random preload and edge count ----
      for (int t = 0; t < 10; t++) begin
         int c, k;
         bit lvl;
         c = int'($urandom % 16);
         k = 1 + int'($urandom % 20);
         scl_to(0);
         lvl = 1'b0;
         reg_wr(A_STAT, 8'hE0 | 8'(c));
         for (int e = 0; e < k; e++) begin
            lvl = ~lvl;
            scl_to(lvl);
         end
         reg_rd(A_STAT, v);
         chk("R5", "random edge count", v, exp_stat(0, (c + k) >= 16, 0, 0, (c + k) % 16));
         reg_wr(A_STAT, 8'h0A);
         reg_rd(A_STAT, v);
         chk("R9", "count load keeps flags", v, exp_stat(0, (c + k) >= 16, 0, 0, 10));
         scl_to(1);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL all watchdog: actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule